// File: doc/BRIEF.md
# SPI Register Port for a Clock Register Space

This block is the serial front end of a small timekeeping device. An SPI master opens a frame by raising the chip select. The first byte of the frame carries a read/write flag and a start address. Every byte after it moves one register, and the address steps up by one per byte. The register space holds the time and date bytes, two alarm sets, a control register, a status register, a charger configuration byte and a scratch RAM. All of these are held inside the block. Each accepted write is also announced on a byte-wide strobe bus, so the timekeeping logic beside the block can follow updates.

The block runs on a system clock that is at least eight times faster than SCLK. The three SPI inputs pass through synchronizers, and SCLK edges are detected in the system clock domain. SPI mode is CPOL=0, CPHA=1. The master changes MOSI on the rising SCLK edge and the block samples it on the falling edge. MISO changes shortly after each falling edge. Bytes travel MSB first.

Top module: `spi_rtc_regs`

## Requirements
- R1: In the first byte of a frame, bit 7 set selects a write frame and bit 7 clear selects a read frame. Bits 6:0 give the start address.
- R2: Chip select is active high. MOSI is sampled on the falling SCLK edge, and bytes are MSB first in both directions.
- R3: Each data byte moves to the next address. The address is 7 bits wide and wraps from 0x7F to 0x00.
- R4: Addresses 0x00–0x11 and 0x20–0x7F hold registers. Addresses 0x12–0x1F read as 0x00, and writes to them are dropped without a strobe.
- R5: Bit 6 of the control register at 0x0F is a write lock. While it is set, writes to every address except 0x0F are dropped. A write that changes the lock applies to the next byte of the same burst.
- R6: A write is committed only after the eighth falling SCLK edge of a data byte. It raises reg_we for exactly one clock, with reg_waddr and reg_wdata, and only for writes that are accepted.
- R7: Read data for an address is loaded at the falling edge that ends the previous byte. Its bit 7 is on MISO before the first rising edge of its own byte.
- R8: Dropping chip select aborts the frame at any bit. A partial data byte is never committed, and the next frame starts again with an address byte.
- R9: After reset all registers hold 0x00, MISO is 0 and reg_we is 0.
- R10: MISO is 0 while chip select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x SCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs | input | 1 | Chip select, active high |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| reg_we | output | 1 | One-clock strobe for an accepted write |
| reg_waddr | output | 7 | Address of the accepted write |
| reg_wdata | output | 8 | Data of the accepted write |

## Verification
Several burst shapes are run against a behavioural model of the register space:
- A seven-byte time write followed by a read-back shows that addressing, auto-increment and bit order are correct.
- A burst that enters the unused hole shows that mapped storage is kept apart from the read-as-zero range.
- A burst that starts at 0x7E checks the address wrap.
- Bursts that set the lock, try to write blocked addresses, and then clear the lock partway through a frame show when the lock takes effect.
- Frames cut off inside a data byte or inside the address byte show that partial bytes are thrown away.

// File: rtl/spi_rtc_pkg.sv
package spi_rtc_pkg;
  localparam int ADDR_W    = 7;
  localparam int DATA_W    = 8;
  localparam int CTRL_ADDR = 'h0F;
  localparam int LOCK_BIT  = 6;
  localparam int REG_TOP   = 'h11;
  localparam int RAM_BASE  = 'h20;

  typedef enum logic [1:0] {
    PH_ADDR  = 2'd0,
    PH_WRITE = 2'd1,
    PH_READ  = 2'd2
  } phase_t;

  function automatic logic addr_mapped(input logic [ADDR_W-1:0] a);
    return (a <= ADDR_W'(REG_TOP)) || (a >= ADDR_W'(RAM_BASE));
  endfunction
endpackage

// File: rtl/spi_sync_chain.sv
module spi_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = d_in;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], d_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_rtc_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          sclk_fall,
  input  logic          mosi_s,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          miso,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam int BC_W = $clog2(DW);

  logic [BC_W-1:0] bitcnt_q, bitcnt_d;
  logic [DW-1:0]   rx_q, rx_d, tx_q, tx_d, rx_full;
  logic [AW-1:0]   ptr_q, ptr_d, ptr_inc;
  phase_t          phase_q, phase_d;
  logic            wr_req_q, wr_req_d;
  logic [AW-1:0]   wr_addr_q, wr_addr_d;
  logic [DW-1:0]   wr_data_q, wr_data_d;
  logic            last_bit;

  assign rx_full  = {rx_q[DW-2:0], mosi_s};
  assign last_bit = (bitcnt_q == BC_W'(DW-1));
  assign ptr_inc  = ptr_q + AW'(1);
  assign rd_addr  = (phase_q == PH_ADDR) ? rx_full[AW-1:0] : ptr_inc;

  always_comb begin
    bitcnt_d  = bitcnt_q;
    rx_d      = rx_q;
    tx_d      = tx_q;
    ptr_d     = ptr_q;
    phase_d   = phase_q;
    wr_req_d  = 1'b0;
    wr_addr_d = wr_addr_q;
    wr_data_d = wr_data_q;
    if (!cs_s) begin
      bitcnt_d = '0;
      rx_d     = '0;
      tx_d     = '0;
      phase_d  = PH_ADDR;
    end else if (sclk_fall) begin
      rx_d     = rx_full;
      bitcnt_d = last_bit ? '0 : bitcnt_q + BC_W'(1);
      if (last_bit) begin
        unique case (phase_q)
          PH_ADDR: begin
            ptr_d   = rx_full[AW-1:0];
            phase_d = rx_full[DW-1] ? PH_WRITE : PH_READ;
            tx_d    = rx_full[DW-1] ? '0 : rd_data;
          end
          PH_WRITE: begin
            wr_req_d  = 1'b1;
            wr_addr_d = ptr_q;
            wr_data_d = rx_full;
            ptr_d     = ptr_inc;
          end
          PH_READ: begin
            tx_d  = rd_data;
            ptr_d = ptr_inc;
          end
          default: phase_d = PH_ADDR;
        endcase
      end else begin
        tx_d = {tx_q[DW-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt_q  <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      phase_q   <= PH_ADDR;
      wr_req_q  <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      bitcnt_q  <= bitcnt_d;
      rx_q      <= rx_d;
      tx_q      <= tx_d;
      ptr_q     <= ptr_d;
      phase_q   <= phase_d;
      wr_req_q  <= wr_req_d;
      wr_addr_q <= wr_addr_d;
      wr_data_q <= wr_data_d;
    end
  end

  assign miso    = tx_q[DW-1];
  assign wr_req  = wr_req_q;
  assign wr_addr = wr_addr_q;
  assign wr_data = wr_data_q;
endmodule

// File: rtl/rtc_reg_store.sv
module rtc_reg_store
  import spi_rtc_pkg::*;
#(
  parameter int            AW        = ADDR_W,
  parameter int            DW        = DATA_W,
  parameter int            CTRL_AD   = CTRL_ADDR,
  parameter int            LOCK_POS  = LOCK_BIT,
  parameter int            TOP_REG   = REG_TOP,
  parameter int            RAM_LO    = RAM_BASE,
  parameter logic [DW-1:0] CTRL_RST  = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          lock,
  output logic          reg_we,
  output logic [AW-1:0] reg_waddr,
  output logic [DW-1:0] reg_wdata
);
  localparam int NREG = 2 ** AW;

  logic [NREG-1:0][DW-1:0] cells;
  logic                    mapped_w;
  logic                    accept;

  assign mapped_w = (wr_addr <= AW'(TOP_REG)) || (wr_addr >= AW'(RAM_LO));
  assign lock     = cells[CTRL_AD][LOCK_POS];
  assign accept   = wr_req && mapped_w && (!lock || (wr_addr == AW'(CTRL_AD)));

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_cell
      if ((i <= TOP_REG) || (i >= RAM_LO)) begin : g_reg
        logic [DW-1:0] cell_q;
        logic          hit;
        assign hit = accept && (wr_addr == AW'(i));
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)   cell_q <= (i == CTRL_AD) ? CTRL_RST : '0;
          else if (hit) cell_q <= wr_data;
        end
        assign cells[i] = cell_q;
      end else begin : g_hole
        assign cells[i] = '0;
      end
    end
  endgenerate

  assign rd_data   = cells[rd_addr];
  assign reg_we    = accept;
  assign reg_waddr = wr_addr;
  assign reg_wdata = wr_data;
endmodule

// File: rtl/spi_rtc_regs.sv
module spi_rtc_regs
  import spi_rtc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int AW          = ADDR_W,
  parameter int DW          = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sclk,
  input  logic          spi_cs,
  input  logic          spi_mosi,
  output logic          spi_miso,
  output logic          reg_we,
  output logic [AW-1:0] reg_waddr,
  output logic [DW-1:0] reg_wdata
);
  logic          rst_meta_q, rst_sync_n;
  logic          cs_s, sclk_s, mosi_s, sclk_hist_q, sclk_fall;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data, wr_data;
  logic          wr_req, lock_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  spi_sync_chain #(.STAGES(SYNC_STAGES)) u_sync_cs (
    .clk(clk), .rst_n(rst_sync_n), .d_in(spi_cs), .q(cs_s));
  spi_sync_chain #(.STAGES(SYNC_STAGES)) u_sync_sclk (
    .clk(clk), .rst_n(rst_sync_n), .d_in(spi_sclk), .q(sclk_s));
  spi_sync_chain #(.STAGES(SYNC_STAGES)) u_sync_mosi (
    .clk(clk), .rst_n(rst_sync_n), .d_in(spi_mosi), .q(mosi_s));

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) sclk_hist_q <= 1'b0;
    else             sclk_hist_q <= sclk_s;
  end
  assign sclk_fall = sclk_hist_q & ~sclk_s;

  spi_frame_engine #(.AW(AW), .DW(DW)) u_engine (
    .clk(clk), .rst_n(rst_sync_n), .cs_s(cs_s), .sclk_fall(sclk_fall),
    .mosi_s(mosi_s), .rd_data(rd_data), .rd_addr(rd_addr), .miso(spi_miso),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data));

  rtc_reg_store #(.AW(AW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_sync_n), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .lock(lock_flag),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata));
endmodule

// File: rtl/spi_rtc_regs_chk.sv
module spi_rtc_regs_chk
  import spi_rtc_pkg::*;
(
  input logic              clk,
  input logic              rst_sync_n,
  input logic              cs_s,
  input logic              sclk_fall,
  input logic              lock_flag,
  input logic              spi_miso,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_waddr
);
  // R6
  we_single_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_we |=> !reg_we);
  // R6
  we_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_we |-> $past(sclk_fall));
  // R5
  lock_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_we && reg_waddr != ADDR_W'(CTRL_ADDR)) |-> !lock_flag);
  // R4
  hole_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_we |-> addr_mapped(reg_waddr));
  // R10
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cs_s |=> !spi_miso);
  // R8
  abort_no_we_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cs_s |=> !reg_we);
endmodule

bind spi_rtc_regs spi_rtc_regs_chk u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .cs_s(cs_s), .sclk_fall(sclk_fall),
  .lock_flag(lock_flag), .spi_miso(spi_miso), .reg_we(reg_we),
  .reg_waddr(reg_waddr));

// File: tb/tb_spi_rtc_regs.sv
module tb_spi_rtc_regs;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 8;

  logic       clk, rst_n, spi_sclk, spi_cs, spi_mosi;
  logic       spi_miso, reg_we;
  logic [6:0] reg_waddr;
  logic [7:0] reg_wdata;

  int checks = 0;
  int errors = 0;
  int cs_low_cnt = 0;
  bit mon_on = 0;
  logic [7:0] ref_mem [128];
  int exp_a[$];
  int exp_d[$];
  logic [7:0] wbuf[$];

  spi_rtc_regs dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs(spi_cs),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .reg_we(reg_we),
    .reg_waddr(reg_waddr), .reg_wdata(reg_wdata));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit mapped(input int a);
    return (a <= 'h11) || (a >= 'h20);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // per-clock comparison against the model's strobe queue and idle MISO
  always @(negedge clk) begin
    if (mon_on) begin
      if (reg_we) begin
        if (exp_a.size() == 0) check(0, "R6 unexpected strobe", int'(reg_waddr), -1);
        else begin
          int ea, ed;
          ea = exp_a.pop_front();
          ed = exp_d.pop_front();
          check(int'(reg_waddr) == ea && int'(reg_wdata) == ed, "R6 strobe addr/data",
                {reg_waddr, reg_wdata}, (ea << 8) | ed);
        end
      end
      if (!spi_cs) cs_low_cnt++;
      else cs_low_cnt = 0;
      if (cs_low_cnt > 6) check(spi_miso == 1'b0, "R10 miso idle", spi_miso, 0);
    end
  end

  task automatic send_bits(input logic [7:0] b, input int nbits, output logic [7:0] got);
    got = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      spi_sclk = 1'b1;
      spi_mosi = b[i];
      wait_clk(HALF_SCK);
      got[i] = spi_miso;
      spi_sclk = 1'b0;
      wait_clk(HALF_SCK);
    end
  endtask

  task automatic frame_open();
    wait_clk(1);
    spi_cs = 1'b1;
    wait_clk(HALF_SCK);
  endtask

  task automatic frame_close();
    wait_clk(HALF_SCK);
    spi_cs = 1'b0;
    wait_clk(3 * HALF_SCK);
  endtask

  // R1 write frame: header bit 7 set; model applies map and lock rules
  task automatic write_burst(input int a);
    logic [7:0] dummy;
    int ad;
    ad = a;
    frame_open();
    send_bits(8'h80 | 8'(a), 8, dummy);
    foreach (wbuf[k]) begin
      if (mapped(ad) && (!ref_mem['h0F][6] || ad == 'h0F)) begin
        ref_mem[ad] = wbuf[k];
        exp_a.push_back(ad);
        exp_d.push_back(int'(wbuf[k]));
      end
      send_bits(wbuf[k], 8, dummy);
      ad = (ad + 1) & 'h7F;
    end
    frame_close();
    check(exp_a.size() == 0, "R6 all strobes seen", exp_a.size(), 0);
    exp_a.delete();
    exp_d.delete();
    wbuf.delete();
  endtask

  // R1 read frame, R2 MSB-first, R7 prefetch
  task automatic read_burst(input int a, input int n, input string req);
    logic [7:0] got;
    int ad, e;
    ad = a;
    frame_open();
    send_bits(8'(a), 8, got);
    for (int k = 0; k < n; k++) begin
      send_bits(8'h00, 8, got);
      e = mapped(ad) ? int'(ref_mem[ad]) : 0;
      check(int'(got) == e, req, int'(got), e);
      ad = (ad + 1) & 'h7F;
    end
    frame_close();
  endtask

  task automatic abort_frame(input logic [7:0] hdr, input int data_bits);
    logic [7:0] dummy;
    frame_open();
    send_bits(hdr, 8, dummy);
    if (data_bits > 0) send_bits(8'hFF, data_bits, dummy);
    spi_cs = 1'b0;
    wait_clk(3 * HALF_SCK);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 128; i++) ref_mem[i] = 8'h00;
    rst_n = 1'b0; spi_sclk = 1'b0; spi_cs = 1'b0; spi_mosi = 1'b0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(6);
    // R9 reset state at the ports
    check(spi_miso == 1'b0, "R9 miso after reset", spi_miso, 0);
    check(reg_we == 1'b0, "R9 strobe after reset", reg_we, 0);
    mon_on = 1;
    read_burst('h0F, 3, "R9 control/status/charger reset");
    read_burst('h20, 2, "R9 ram reset");

    // R1 R3 time block burst write and read-back
    wbuf = '{8'h59, 8'h30, 8'h12, 8'h03, 8'h15, 8'h06, 8'h24};
    write_burst('h00);
    read_burst('h00, 7, "R3 time burst readback");

    // R4 unused hole ignores writes and reads zero
    wbuf = '{8'h55, 8'h66};
    write_burst('h12);
    read_burst('h10, 4, "R4 hole reads zero");

    // R3 address wrap 0x7F -> 0x00
    wbuf = '{8'hAA, 8'hBB, 8'hCC};
    write_burst('h7E);
    read_burst('h7E, 3, "R3 wrap readback");

    // R5 lock set blocks other writes
    wbuf = '{8'h40};
    write_burst('h0F);
    wbuf = '{8'h11, 8'h22};
    write_burst('h20);
    read_burst('h20, 2, "R5 locked ram unchanged");
    // R5 burst: 0x0E blocked, 0x0F clears lock, 0x10 then accepted
    wbuf = '{8'h99, 8'h00, 8'h88};
    write_burst('h0E);
    read_burst('h0E, 3, "R5 lock cleared mid-burst");

    // R8 abort inside a data byte
    abort_frame(8'hA1, 5);
    read_burst('h21, 1, "R8 partial byte dropped");
    // R8 abort inside the address byte, then a clean frame
    frame_open();
    begin
      logic [7:0] dummy;
      send_bits(8'h80, 3, dummy);
    end
    spi_cs = 1'b0;
    wait_clk(3 * HALF_SCK);
    wbuf = '{8'h5A};
    write_burst('h30);
    read_burst('h30, 1, "R8 frame after aborted address");

    // R2 bit order with an asymmetric pattern
    wbuf = '{8'h01, 8'h80};
    write_burst('h40);
    read_burst('h40, 2, "R2 msb-first order");

    finish_run();
  end
endmodule